// File: doc/BRIEF.md
# Byte-Wide FPGA Configuration Loader

This controller carries a configuration image from an upstream byte stream into an FPGA through the device's byte-wide slave parallel configuration port. A start pulse, given together with the total number of bytes, begins a load. The loader pulses the program pin for a settle interval. It then waits until the device reports that it is ready, asserts chip-select and write, and moves one byte per rising edge of the configuration clock. When BUSY checking is enabled, it adds clock pulses while the device reports BUSY. After the last byte it releases the port and keeps clocking until DONE rises.

Every wait for the device has its own cycle-counted timeout. A timeout ends the load with a one-cycle abort pulse, a sticky fail flag and a code that names the wait that expired. Within this block every pin is active-high: a high `prog_o` means program is asserted, and a high `init_i` means the device has released INIT and is ready. The byte input is a valid/ready stream. `s_ready_o` goes high only in the phase where the next byte is driven onto the pins. A byte moves on a clock where `s_valid_i` and `s_ready_o` are both high, and `s_data_i` must stay steady while `s_valid_i` is held waiting. A low `s_valid_i` only holds the configuration clock high and lengthens the load, so back-pressure never drops a byte. Each clock phase lasts `PHASE_CYC` system cycles. Raising that value slows the port down for slow boards.

Top module: `cfg_par_loader`

## Requirements
- R1: Out of reset and while idle: `prog_o`, `cs_o`, `wr_o`, `s_ready_o`, `abort_o`, `done_o` and `fail_o` are low, `cclk_o` is high and `tmo_o` is 0.
- R2: A `start_i` seen while idle holds `prog_o` high for exactly `SETTLE_CYC` cycles and clears the previous status. A `start_i` seen during a load has no effect.
- R3: After program is released, the loader waits for `init_i` high with `busy_i` low. If that does not happen within `TIMEOUT_CYC` cycles (allowing two cycles of slack), the load fails with `tmo_o` = 1.
- R4: `cs_o` and `wr_o` rise together while `cclk_o` is high, before the first byte. `s_ready_o` is high only while `cs_o`, `wr_o` and `cclk_o` are all high.
- R5: For each accepted byte, `d_o` holds the byte while `cclk_o` is low for `PHASE_CYC` cycles and then high for `PHASE_CYC` cycles. There is exactly one rising edge per byte, and the bytes go out in stream order.
- R6: When BUSY is high at the end of a byte's high phase, the loader gives one extra clock pulse per cycle in which BUSY stays high. No byte is taken during these pulses. A BUSY that outlasts `TIMEOUT_CYC` ends the load with `tmo_o` = 2.
- R7: Whenever the port is released, `cs_o` falls one cycle before `wr_o`. This holds both after the last byte and on failure.
- R8: After the data, the loader gives one clock pulse per check until `done_i` is high, then sets `done_o`. A DONE that does not arrive within `TIMEOUT_CYC` gives `tmo_o` = 3. `done_o` and `fail_o` are never high together.
- R9: On a timeout, `abort_o` is high for exactly one cycle and `fail_o` is set and held until the next start. At the end, `prog_o`, `cs_o` and `wr_o` are low.
- R10: While `s_valid_i` is low in the data phase, the clock stays high and no byte is lost or repeated.
- R11: A byte count of 0 goes straight from the ready wait to the DONE wait without asserting `cs_o` or `wr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begins a load when idle |
| byte_count_i | input | CNT_W | Number of bytes in the image, sampled at start |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | 8 | Stream byte |
| s_ready_o | output | 1 | Loader accepts a byte this cycle |
| prog_o | output | 1 | Program pin, high = asserted |
| cs_o | output | 1 | Chip-select, high = asserted |
| wr_o | output | 1 | Write enable, high = asserted |
| cclk_o | output | 1 | Configuration clock |
| d_o | output | 8 | Configuration data pins |
| init_i | input | 1 | High = device ready (INIT released) |
| busy_i | input | 1 | High = device busy |
| done_i | input | 1 | High = configuration finished |
| done_o | output | 1 | Load succeeded (sticky until next start) |
| fail_o | output | 1 | Load failed (sticky until next start) |
| tmo_o | output | 2 | Expired wait: 0 none, 1 ready, 2 busy, 3 done |
| abort_o | output | 1 | One-cycle pulse on failure |

## Verification
The assertions check on every cycle the relations between the pins. Ready only appears while the port is selected and the clock is high. Data is stable through a low clock phase. Write never falls before chip-select. Program excludes port activity. An abort is always followed by a held fail flag and never coincides with success. What the pins cannot show cycle by cycle needs the bench's device model: bytes arriving in order, the exact counts of extra BUSY and DONE pulses, the length of the program pulse, the timeout distance for each wait, and the behaviour under input stalls, a zero-length image and a repeated start.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PROG,
    ST_WAIT_RDY,
    ST_FEED,
    ST_LO,
    ST_HI,
    ST_REL_CS,
    ST_DONE_CHK,
    ST_FAIL
  } cfgl_state_e;

  // code values appear on tmo_o
  typedef enum logic [1:0] {
    WK_NONE  = 2'd0,
    WK_READY = 2'd1,
    WK_BUSY  = 2'd2,
    WK_DONE  = 2'd3
  } cfgl_wait_e;

  typedef enum logic [1:0] {
    PP_DATA,
    PP_BUSY,
    PP_DONE
  } cfgl_pulse_e;
endpackage

// File: rtl/cfgl_interval.sv
// Down-counter that times a program pulse or one configuration clock phase.
module cfgl_interval #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             expire_o
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= len_i - LEN_W'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - LEN_W'(1);
    end
  end

  assign expire_o = (cnt_q == '0);

  AST_IV_LOAD_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && len_i > LEN_W'(1)) |=> !expire_o); // R5
endmodule

// File: rtl/cfgl_watchdog.sv
// Saturating cycle counter that bounds one wait phase.
module cfgl_watchdog #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int W = $clog2(LIMIT + 1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart_i) begin
      cnt_q <= '0;
    end else if (run_i && !expired_o) begin
      cnt_q <= cnt_q + W'(1);
    end
  end

  assign expired_o = (cnt_q == W'(LIMIT));

  AST_WD_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (expired_o && !restart_i) |=> expired_o); // R3
  AST_WD_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> !expired_o); // R6
endmodule

// File: rtl/cfg_par_loader.sv
module cfg_par_loader
  import cfgl_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DATA_W      = 8,
  parameter int PHASE_CYC   = 1,
  parameter int SETTLE_CYC  = 16,
  parameter int TIMEOUT_CYC = 1000000,
  parameter bit BUSY_CHECK  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  byte_count_i,
  input  logic              s_valid_i,
  input  logic [DATA_W-1:0] s_data_i,
  output logic              s_ready_o,
  output logic              prog_o,
  output logic              cs_o,
  output logic              wr_o,
  output logic              cclk_o,
  output logic [DATA_W-1:0] d_o,
  input  logic              init_i,
  input  logic              busy_i,
  input  logic              done_i,
  output logic              done_o,
  output logic              fail_o,
  output logic [1:0]        tmo_o,
  output logic              abort_o
);
  localparam int MAX_LEN = (PHASE_CYC > SETTLE_CYC) ? PHASE_CYC : SETTLE_CYC;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);

  cfgl_state_e state_q, state_d;
  cfgl_pulse_e pulse_q, pulse_d;
  cfgl_wait_e  wait_q, wait_d, tmo_q, tmo_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic cs_q, cs_d, wr_q, wr_d, done_q, done_d, fail_q, fail_d;
  logic iv_load, iv_expire, wd_restart, wd_expired, busy_seen;
  logic [LEN_W-1:0] iv_len;

  generate
    if (BUSY_CHECK) begin : g_busy
      assign busy_seen = busy_i;
    end else begin : g_nobusy
      assign busy_seen = 1'b0;
    end
  endgenerate

  cfgl_interval #(.LEN_W(LEN_W)) u_interval (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (iv_load),
    .len_i    (iv_len),
    .expire_o (iv_expire)
  );

  cfgl_watchdog #(.LIMIT(TIMEOUT_CYC)) u_watchdog (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (wd_restart),
    .run_i     (wait_q != WK_NONE),
    .expired_o (wd_expired)
  );

  always_comb begin
    state_d    = state_q;
    pulse_d    = pulse_q;
    wait_d     = wait_q;
    tmo_d      = tmo_q;
    left_d     = left_q;
    data_d     = data_q;
    cs_d       = cs_q;
    wr_d       = wr_q;
    done_d     = done_q;
    fail_d     = fail_q;
    iv_load    = 1'b0;
    iv_len     = LEN_W'(PHASE_CYC);
    wd_restart = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_PROG;
          iv_load = 1'b1;
          iv_len  = LEN_W'(SETTLE_CYC);
          left_d  = byte_count_i;
          done_d  = 1'b0;
          fail_d  = 1'b0;
          tmo_d   = WK_NONE;
        end
      end
      ST_PROG: begin
        if (iv_expire) begin
          state_d    = ST_WAIT_RDY;
          wait_d     = WK_READY;
          wd_restart = 1'b1;
        end
      end
      ST_WAIT_RDY: begin
        if (init_i && !busy_i) begin
          if (left_q == '0) begin
            state_d    = ST_DONE_CHK;
            wait_d     = WK_DONE;
            wd_restart = 1'b1;
          end else begin
            state_d = ST_FEED;
            wait_d  = WK_NONE;
            cs_d    = 1'b1;
            wr_d    = 1'b1;
          end
        end else if (wd_expired) begin
          state_d = ST_FAIL;
          tmo_d   = wait_q;
          wait_d  = WK_NONE;
          cs_d    = 1'b0;
        end
      end
      ST_FEED: begin
        if (s_valid_i) begin
          data_d  = s_data_i;
          left_d  = left_q - CNT_W'(1);
          pulse_d = PP_DATA;
          state_d = ST_LO;
          iv_load = 1'b1;
        end
      end
      ST_LO: begin
        if (iv_expire) begin
          state_d = ST_HI;
          iv_load = 1'b1;
        end
      end
      ST_HI: begin
        if (iv_expire) begin
          case (pulse_q)
            PP_DATA: begin
              if (busy_seen) begin
                pulse_d    = PP_BUSY;
                wait_d     = WK_BUSY;
                wd_restart = 1'b1;
                state_d    = ST_LO;
                iv_load    = 1'b1;
              end else if (left_q == '0) begin
                state_d = ST_REL_CS;
                cs_d    = 1'b0;
              end else begin
                state_d = ST_FEED;
              end
            end
            PP_BUSY: begin
              if (wd_expired) begin
                state_d = ST_FAIL;
                tmo_d   = wait_q;
                wait_d  = WK_NONE;
                cs_d    = 1'b0;
              end else if (busy_seen) begin
                state_d = ST_LO;
                iv_load = 1'b1;
              end else begin
                wait_d = WK_NONE;
                if (left_q == '0) begin
                  state_d = ST_REL_CS;
                  cs_d    = 1'b0;
                end else begin
                  state_d = ST_FEED;
                end
              end
            end
            default: state_d = ST_DONE_CHK;
          endcase
        end
      end
      ST_REL_CS: begin
        wr_d       = 1'b0;
        state_d    = ST_DONE_CHK;
        wait_d     = WK_DONE;
        wd_restart = 1'b1;
      end
      ST_DONE_CHK: begin
        if (done_i) begin
          done_d  = 1'b1;
          wait_d  = WK_NONE;
          state_d = ST_IDLE;
        end else if (wd_expired) begin
          state_d = ST_FAIL;
          tmo_d   = wait_q;
          wait_d  = WK_NONE;
          cs_d    = 1'b0;
        end else begin
          pulse_d = PP_DONE;
          state_d = ST_LO;
          iv_load = 1'b1;
        end
      end
      ST_FAIL: begin
        wr_d    = 1'b0;
        fail_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pulse_q <= PP_DATA;
      wait_q  <= WK_NONE;
      tmo_q   <= WK_NONE;
      left_q  <= '0;
      data_q  <= '0;
      cs_q    <= 1'b0;
      wr_q    <= 1'b0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse_q <= pulse_d;
      wait_q  <= wait_d;
      tmo_q   <= tmo_d;
      left_q  <= left_d;
      data_q  <= data_d;
      cs_q    <= cs_d;
      wr_q    <= wr_d;
      done_q  <= done_d;
      fail_q  <= fail_d;
    end
  end

  assign s_ready_o = (state_q == ST_FEED);
  assign prog_o    = (state_q == ST_PROG);
  assign cclk_o    = (state_q != ST_LO);
  assign abort_o   = (state_q == ST_FAIL);
  assign cs_o      = cs_q;
  assign wr_o      = wr_q;
  assign d_o       = data_q;
  assign done_o    = done_q;
  assign fail_o    = fail_q;
  assign tmo_o     = tmo_q;

  AST_READY_IN_PORT_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready_o |-> (cs_o && wr_o && cclk_o)); // R4
  AST_PROG_PORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    prog_o |-> (!cs_o && !wr_o && cclk_o && !s_ready_o)); // R2
  AST_DATA_STABLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!cclk_o && $past(!cclk_o)) |-> $stable(d_o)); // R5
  AST_CS_BEFORE_WR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_o) |-> (!cs_o && $past(!cs_o))); // R7
  AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> (!abort_o && fail_o && !cs_o && !wr_o)); // R9
  AST_DONE_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && fail_o)); // R8
endmodule

// File: tb/test_cfg_par_loader.sv
module test_cfg_par_loader;
  localparam int PH  = 2;
  localparam int SET = 3;
  localparam int TMO = 300;
  localparam int NEVER = 1000000;

  typedef struct packed {
    int n; int init_dly; int busy_at; int busy_n; int done_n; int gaps; int exp_tmo;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{4,  5,     0, 0,     0,     0, 0},
    '{16, 20,    3, 2,     3,     1, 0},
    '{1,  0,     1, 5,     1,     0, 0},
    '{0,  2,     0, 0,     2,     0, 0},
    '{3,  NEVER, 0, 0,     0,     0, 1},
    '{5,  1,     2, NEVER, 0,     0, 2},
    '{2,  1,     0, 0,     NEVER, 1, 3}
  };

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, s_valid_i = 1'b0;
  logic [15:0] byte_count_i = '0;
  logic [7:0] s_data_i = '0, d_o;
  logic s_ready_o, prog_o, cs_o, wr_o, cclk_o, init_i, busy_i, done_i;
  logic done_o, fail_o, abort_o;
  logic [1:0] tmo_o;
  int errors = 0, checks = 0;

  // device model configuration and state
  logic mdl_rst = 1'b1;
  int n_cfg = 0, init_cfg = 0, busy_at_cfg = 0, busy_n_cfg = 0, done_cfg = 0;
  int cap_n, busy_left, post_n, cs_edges, init_cnt;
  logic [7:0] cap [32];
  logic init_q;

  always #4 clk = ~clk;

  cfg_par_loader #(.PHASE_CYC(PH), .SETTLE_CYC(SET), .TIMEOUT_CYC(TMO)) i_cfg_par_loader (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_count_i(byte_count_i),
    .s_valid_i(s_valid_i), .s_data_i(s_data_i), .s_ready_o(s_ready_o),
    .prog_o(prog_o), .cs_o(cs_o), .wr_o(wr_o), .cclk_o(cclk_o), .d_o(d_o),
    .init_i(init_i), .busy_i(busy_i), .done_i(done_i),
    .done_o(done_o), .fail_o(fail_o), .tmo_o(tmo_o), .abort_o(abort_o));

  always @(posedge cclk_o or posedge mdl_rst) begin
    if (mdl_rst) begin
      cap_n <= 0; busy_left <= 0; post_n <= 0; cs_edges <= 0;
    end else if (cs_o) begin
      cs_edges <= cs_edges + 1;
      if (busy_left > 0) busy_left <= busy_left - 1;
      else if (wr_o && cap_n < 32) begin
        cap[cap_n] <= d_o;
        cap_n <= cap_n + 1;
        if (cap_n + 1 == busy_at_cfg) busy_left <= busy_n_cfg;
      end
    end else if (cap_n == n_cfg) begin
      post_n <= post_n + 1;
    end
  end

  always @(posedge clk or posedge mdl_rst) begin
    if (mdl_rst) begin
      init_q <= 1'b0; init_cnt <= 0;
    end else if (prog_o) begin
      init_q <= 1'b0; init_cnt <= 0;
    end else if (init_cnt >= init_cfg) begin
      init_q <= 1'b1;
    end else begin
      init_cnt <= init_cnt + 1;
    end
  end

  assign init_i = init_q;
  assign busy_i = (busy_left != 0);
  assign done_i = (cap_n == n_cfg) && (post_n >= done_cfg);

  function automatic logic [7:0] pat(int t, int i);
    return 8'((i * 37 + t * 59 + 3) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input int t, input vec_t v, input bit mid_start);
    int idx = 0, prog_len = 0, prog_rises = 0, aborts = 0, wait_cyc = 0, lo_run = 0;
    int cs_rises = 0;
    bit fire_prev = 0, bad_phase = 0, bad_order = 0, bad_ready = 0, bad_rise = 0;
    bit fell = 0, mid_sent = 0, prev_prog = 0, prev_cs = 0, prev_wr = 0, fin = 0;
    @(negedge clk);
    n_cfg = v.n; init_cfg = v.init_dly; busy_at_cfg = v.busy_at;
    busy_n_cfg = v.busy_n; done_cfg = v.done_n;
    byte_count_i = 16'(v.n);
    mdl_rst = 1'b1;
    @(negedge clk);
    mdl_rst = 1'b0;
    for (int cyc = 0; cyc < 20000 && !fin; cyc++) begin
      @(negedge clk);
      if (prog_o) prog_len++;
      if (prog_o && !prev_prog) prog_rises++;
      if (!prog_o && prev_prog) fell = 1;
      if (fell && !abort_o && !fail_o && !done_o) wait_cyc++;
      if (abort_o) aborts++;
      if (cs_o && !prev_cs) begin
        cs_rises++;
        if (!(wr_o && cclk_o)) bad_rise = 1;
      end
      if (prev_wr && !wr_o && (cs_o || prev_cs)) bad_order = 1;
      if (s_ready_o && !(cs_o && wr_o && cclk_o)) bad_ready = 1;
      if (!cclk_o) lo_run++;
      else begin
        if (lo_run != 0 && lo_run != PH) bad_phase = 1;
        lo_run = 0;
      end
      prev_prog = prog_o; prev_cs = cs_o; prev_wr = wr_o;
      if (cyc > 1 && (done_o || fail_o)) fin = 1;
      if (fire_prev) idx++;
      s_valid_i = (idx < v.n) && (v.gaps == 0 || cyc % 3 == 0);
      s_data_i = pat(t, idx);
      fire_prev = s_valid_i && s_ready_o;
      start_i = (cyc == 0);
      if (mid_start && !mid_sent && cap_n == 2) begin
        start_i = 1'b1; mid_sent = 1;
      end
    end
    start_i = 1'b0; s_valid_i = 1'b0;
    @(negedge clk);
    chk(prog_len == SET, "R2", "program pulse length", prog_len, SET);
    chk(prog_rises == 1, "R2", "program pulses per load", prog_rises, 1);
    chk(!bad_order, "R7", "cs released before wr", bad_order, 0);
    chk(!bad_ready && !bad_rise, "R4", "port select/ready relation", bad_ready + 2 * bad_rise, 0);
    chk(!bad_phase, "R5", "clock low phase length", bad_phase, 0);
    chk(!prog_o && !cs_o && !wr_o, "R9", "pins released at end", prog_o + cs_o + wr_o, 0);
    if (v.exp_tmo == 0) begin
      chk(done_o && !fail_o && tmo_o == 0, "R8", "success status", {done_o, fail_o, tmo_o}, 8);
      chk(aborts == 0, "R9", "no abort on success", aborts, 0);
      chk(cap_n == v.n, "R5", "bytes captured", cap_n, v.n);
      for (int i = 0; i < v.n && i < 32; i++)
        chk(cap[i] == pat(t, i), (v.gaps != 0) ? "R10" : "R5", "captured byte", cap[i], pat(t, i));
      chk(cs_edges == v.n + v.busy_n, "R6", "selected clock edges", cs_edges, v.n + v.busy_n);
      chk(post_n == v.done_n, "R8", "clock pulses while waiting for done", post_n, v.done_n);
      if (v.n == 0) chk(cs_rises == 0, "R11", "no select for empty image", cs_rises, 0);
    end else begin
      chk(fail_o && !done_o, "R9", "fail status", {fail_o, done_o}, 2);
      chk(aborts == 1, "R9", "abort pulse count", aborts, 1);
      chk(tmo_o == 2'(v.exp_tmo), (v.exp_tmo == 1) ? "R3" : (v.exp_tmo == 2) ? "R6" : "R8",
          "timeout code", tmo_o, v.exp_tmo);
      if (v.exp_tmo == 1) begin
        chk(wait_cyc >= TMO && wait_cyc <= TMO + 2, "R3", "ready wait length", wait_cyc, TMO + 1);
        chk(cs_rises == 0, "R3", "no select without ready", cs_rises, 0);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    mdl_rst = 1'b0;
    @(negedge clk);
    // R1: idle outputs after reset
    chk(!prog_o && !cs_o && !wr_o && !s_ready_o, "R1", "idle port pins", {prog_o, cs_o, wr_o, s_ready_o}, 0);
    chk(cclk_o, "R1", "idle clock high", cclk_o, 1);
    chk(!done_o && !fail_o && !abort_o && tmo_o == 0, "R1", "idle status", {done_o, fail_o, abort_o, tmo_o}, 0);
    for (int t = 0; t < 7; t++) run_vec(t, VECS[t], 1'b0);
    // R2: repeated start during a load is ignored
    run_vec(9, '{6, 3, 0, 0, 1, 0, 0}, 1'b1);
    // R1: back to idle after the last load
    repeat (3) @(negedge clk);
    chk(!s_ready_o && cclk_o && !abort_o, "R1", "idle after load", {s_ready_o, cclk_o, abort_o}, 2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule